// File: doc/BRIEF.md
# Cycle-Paced Saturating Interrupt Timer

This block is an interrupt timer for a cartridge bank controller. The CPU reaches it through two byte-wide registers. One register holds the low eight bits of a 15-bit up-counter. The other holds the upper seven bits together with a run flag. The timer steps once per CPU cycle. That cycle rate comes from a picture-clock enable input, which a divide-by-three prescaler inside the block slows down.

The counter does not wrap. When a step arrives while the count is already all ones, the count stays where it is and a pending flag is set. The interrupt line is the pending flag gated by the run flag. Software usually loads a start value, sets the run flag and waits for the line. It acknowledges the interrupt by writing either count register, which clears the pending flag.

The register strobes are plain single-cycle controls rather than a stream. A write or read is taken on any clock cycle on which its strobe is high. The block never holds the CPU off, so there is no back-pressure to honour. Read data is combinational and is zero while the read strobe is low.

Top module: `cyc_irq_timer`

## Requirements
- R1: After reset the count is 0, the run flag is 0, the pending flag is 0 and `irq` is 0. Both registers read back as 0x00.
- R2: A write with `reg_sel`=0 loads count bits 7:0 from `wr_data` and leaves bits 14:8 unchanged. A read with `reg_sel`=0 returns count bits 7:0.
- R3: A write with `reg_sel`=1 loads count bits 14:8 from `wr_data[6:0]` and the run flag from `wr_data[7]`. A read with `reg_sel`=1 returns the run flag in bit 7 and count bits 14:8 in bits 6:0.
- R4: A write to either register clears the pending flag, so `irq` is 0 from the next cycle.
- R5: While the run flag is set, the count rises by one on every third cycle with `pclk_en` high. Cycles with `pclk_en` low do not advance the count.
- R6: While the run flag is clear, the count does not change however many `pclk_en` pulses arrive.
- R7: A write that changes the run flag from 0 to 1 restarts the prescaler, so the first step follows the third later `pclk_en` pulse. A write with bit 7 set while the timer is already running does not restart the prescaler.
- R8: A step taken at count 0x7FFF leaves the count at 0x7FFF and sets the pending flag. Further steps keep both as they are.
- R9: `irq` is high exactly when the pending flag and the run flag are both set.
- R10: Reads change no state.
- R11: When a register write and a step fall on the same cycle, the written value wins and that step is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pclk_en | input | 1 | One-cycle pulse per picture clock |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_sel | input | 1 | Register select: 0 = low count byte, 1 = run flag and high count bits |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, zero while `rd_en` is low |
| irq | output | 1 | Level interrupt request |

## Verification
The bench counts `pclk_en` pulses exactly around each run-flag write:
- A prescaler that is not restarted on the 0-to-1 transition, or that is restarted on every run-flag write, would make the first step arrive one pulse early or late.
- A counter that wraps instead of saturating would read back 0x0000 and never raise `irq`.
- A design that lets a step overwrite a same-cycle write would read back one above the written value.
- A design that lets a write leave the pending flag set would keep `irq` high after the acknowledge.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;
  typedef enum logic {
    SEL_LOW  = 1'b0,
    SEL_HIGH = 1'b1
  } reg_sel_e;

  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_DIV    = 3;
endpackage

// File: rtl/ctimer_prescale.sv
module ctimer_prescale #(
  parameter int unsigned DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic reload,
  input  logic pclk_en,
  output logic tick
);
  localparam int unsigned PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(DIV - 1);

  logic [PH_W-1:0] phase;

  assign tick = run && pclk_en && (phase == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (reload) begin
      phase <= '0;
    end else if (run && pclk_en) begin
      phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end
  end

  // R6: a stopped prescaler keeps its phase
  a_r6_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !reload) |=> $stable(phase));

  // R5: the phase stays inside the divide range
  a_r5_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= LAST);

  // R7: a restart puts the phase back at zero
  a_r7_reload_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (phase == '0));
endmodule

// File: rtl/ctimer_core.sv
module ctimer_core #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_low,
  input  logic              wr_high,
  input  logic [DATA_W-1:0] wr_data,
  output logic [2*DATA_W-2:0] count,
  output logic              run,
  output logic              pending,
  output logic              run_rise
);
  localparam int unsigned CNT_W = 2 * DATA_W - 1;
  localparam int unsigned HI_W  = CNT_W - DATA_W;
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  assign run_rise = wr_high && wr_data[DATA_W-1] && !run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      run     <= 1'b0;
      pending <= 1'b0;
    end else if (wr_low) begin
      count[DATA_W-1:0] <= wr_data;
      pending           <= 1'b0;
    end else if (wr_high) begin
      count[CNT_W-1:DATA_W] <= wr_data[HI_W-1:0];
      run                   <= wr_data[DATA_W-1];
      pending               <= 1'b0;
    end else if (tick) begin
      if (count == TOP) begin
        pending <= 1'b1;
      end else begin
        count <= count + 1'b1;
      end
    end
  end

  // R8: a step at the top value holds the count and raises pending
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_low && !wr_high && count == TOP) |=> (count == TOP && pending));

  // R4: any register write acknowledges the interrupt
  a_r4_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_low || wr_high) |=> !pending);

  // R5: a step below the top value adds exactly one
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_low && !wr_high && count != TOP) |=> (count == $past(count) + 1'b1));

  // R6: a stopped counter keeps its value unless written
  a_r6_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_low && !wr_high) |=> $stable(count));
endmodule

// File: rtl/ctimer_rdmux.sv
module ctimer_rdmux #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                rd_en,
  input  logic                sel_high,
  input  logic [2*DATA_W-2:0] count,
  input  logic                run,
  output logic [DATA_W-1:0]   rd_data
);
  localparam int unsigned CNT_W = 2 * DATA_W - 1;

  always_comb begin
    if (!rd_en) begin
      rd_data = '0;
    end else if (sel_high) begin
      rd_data = {run, count[CNT_W-1:DATA_W]};
    end else begin
      rd_data = count[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
  import cyc_timer_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned DIV    = DEF_DIV
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pclk_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int unsigned CNT_W = 2 * DATA_W - 1;

  logic             wr_low, wr_high, tick, run, pending, run_rise;
  logic [CNT_W-1:0] count;

  assign wr_low  = wr_en && (reg_sel_e'(reg_sel) == SEL_LOW);
  assign wr_high = wr_en && (reg_sel_e'(reg_sel) == SEL_HIGH);

  ctimer_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .reload(run_rise),
    .pclk_en(pclk_en), .tick(tick)
  );

  ctimer_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_low(wr_low),
    .wr_high(wr_high), .wr_data(wr_data), .count(count), .run(run),
    .pending(pending), .run_rise(run_rise)
  );

  ctimer_rdmux #(.DATA_W(DATA_W)) u_rd (
    .rd_en(rd_en), .sel_high(wr_high | reg_sel), .count(count),
    .run(run), .rd_data(rd_data)
  );

  assign irq = pending && run;

  // R9: the request line never rises without a prior step at the top value
  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick));

  // R1: a reset leaves the line low
  a_r1_reset_low: assert property (@(posedge clk)
    $past(!rst_n) |-> !irq);
endmodule

// File: tb/tb_cyc_irq_timer.sv
module tb_cyc_irq_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pclk_en = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cyc_irq_timer dut (
    .clk(clk), .rst_n(rst_n), .pclk_en(pclk_en), .wr_en(wr_en),
    .rd_en(rd_en), .reg_sel(reg_sel), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq)
  );

  // {sel, wdata, expected low byte, expected high byte}; pclk_en stays low
  localparam logic [24:0] VEC [6] = '{
    {1'b0, 8'h5A, 8'h5A, 8'h00},
    {1'b1, 8'h13, 8'h5A, 8'h13},
    {1'b1, 8'hFF, 8'h5A, 8'hFF},
    {1'b0, 8'h00, 8'h00, 8'hFF},
    {1'b1, 8'h7F, 8'h00, 8'h7F},
    {1'b0, 8'hA5, 8'hA5, 8'h7F}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; reg_sel = sel;
    #1 v = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      pclk_en = 1'b1;
      @(negedge clk);
      pclk_en = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] lo, hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(1'b0, lo); rd(1'b1, hi);
    chk("R1 low", {8'h0, lo}, 16'h0000);
    chk("R1 high", {8'h0, hi}, 16'h0000);
    chk("R1 irq", {15'h0, irq}, 16'h0000);

    // R2 R3 table walk
    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][24], VEC[i][23:16]);
      rd(1'b0, lo); rd(1'b1, hi);
      chk("R2 table low", {8'h0, lo}, {8'h0, VEC[i][15:8]});
      chk("R3 table high", {8'h0, hi}, {8'h0, VEC[i][7:0]});
    end

    // R7 start: first step after third pulse
    wr(1'b0, 8'h00); wr(1'b1, 8'h80);
    pulses(2); rd(1'b0, lo);
    chk("R7 no step after two pulses", {8'h0, lo}, 16'h0000);
    pulses(1); rd(1'b0, lo);
    chk("R7 first step after third pulse", {8'h0, lo}, 16'h0001);
    pulses(3); rd(1'b0, lo);
    chk("R5 step every three pulses", {8'h0, lo}, 16'h0002);
    repeat (20) @(negedge clk);
    rd(1'b0, lo);
    chk("R5 idle cycles do not count", {8'h0, lo}, 16'h0002);

    // R7 no restart when already running
    pulses(1); wr(1'b1, 8'h80); pulses(2); rd(1'b0, lo);
    chk("R7 no restart while running", {8'h0, lo}, 16'h0003);

    // R6 stopped
    wr(1'b1, 8'h00); pulses(6); rd(1'b0, lo);
    chk("R6 stopped count holds", {8'h0, lo}, 16'h0003);

    // R8 saturation, R9 irq
    wr(1'b0, 8'hFD); wr(1'b1, 8'hFF);
    pulses(3); rd(1'b0, lo);
    chk("R8 count FE", {8'h0, lo}, 16'h00FE);
    pulses(3); rd(1'b0, lo); rd(1'b1, hi);
    chk("R8 reached top", {hi, lo}, 16'hFFFF);
    chk("R9 irq low at top before step", {15'h0, irq}, 16'h0000);
    pulses(3); rd(1'b0, lo); rd(1'b1, hi);
    chk("R8 holds at top", {hi, lo}, 16'hFFFF);
    chk("R9 irq raised", {15'h0, irq}, 16'h0001);
    pulses(3); rd(1'b0, lo);
    chk("R8 still at top", {8'h0, lo}, 16'h00FF);
    chk("R9 irq stays", {15'h0, irq}, 16'h0001);

    // R10 reads have no effect
    for (int k = 0; k < 4; k++) begin rd(1'b0, lo); rd(1'b1, hi); end
    chk("R10 reads keep value", {hi, lo}, 16'hFFFF);
    chk("R10 reads keep irq", {15'h0, irq}, 16'h0001);

    // R4 acknowledge by low write
    wr(1'b0, 8'h10);
    chk("R4 low write clears irq", {15'h0, irq}, 16'h0000);
    rd(1'b1, hi);
    chk("R2 high kept on low write", {8'h0, hi}, 16'h00FF);
    // R4 acknowledge by high write
    wr(1'b0, 8'hFF); pulses(3);
    chk("R9 irq raised again", {15'h0, irq}, 16'h0001);
    wr(1'b1, 8'hFF);
    chk("R4 high write clears irq", {15'h0, irq}, 16'h0000);

    // R11 collision: write wins over a same-cycle step
    wr(1'b1, 8'h00); wr(1'b0, 8'h20); wr(1'b1, 8'h80);
    pulses(2);
    @(negedge clk);
    pclk_en = 1'b1; wr_en = 1'b1; reg_sel = 1'b0; wr_data = 8'h40;
    @(negedge clk);
    pclk_en = 1'b0; wr_en = 1'b0;
    rd(1'b0, lo);
    chk("R11 write wins", {8'h0, lo}, 16'h0040);
    pulses(3); rd(1'b0, lo);
    chk("R11 counting resumes", {8'h0, lo}, 16'h0041);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule